// File: doc/BRIEF.md
# Decode-Stage Branch Target Redirect Checker

This block sits in the decode path of an out-of-order core. Each cycle it receives a group of up to `W` instructions in program order, slot 0 being the oldest. Each slot carries a sequence number, a thread id, a predicted-taken bit, the predicted target, the control, direct and unconditional type flags, a target already computed upstream, and a flag saying the instruction reads no source registers. Direct unconditional branches are the only instructions whose destination is fully known at this point. For those, the block compares the computed target against the prediction. When they differ it sends fetch a redirect, squashes the younger work of that thread, and ends the group at the offending branch.

The block forwards the surviving slots with an issuable tag and a corrected target field. It raises a thread flush pulse so the queue and skid buffer of that thread can be emptied. It also flags any instruction that was predicted taken but is not a control instruction. Two running counters record how many branches were checked and how many of them mispredicted. Every output is registered and is due one clock after the group is presented.

Top module: `branch_redirect_chk`

## Requirements
- R1: While `rst_n` is low, every output is zero, including both counters.
- R2: A slot is checked only when it is valid, direct and unconditional. Conditional and indirect slots never cause a redirect. `resolved_cnt` grows by the number of checked slots that are forwarded.
- R3: A checked slot whose computed target differs from its predicted target is a mismatch. The cycle after it is presented, `redir_valid` is 1 and carries that slot's thread id, sequence number and computed target, and `mispred_cnt` grows by one. A redirect stands for mispredict, prediction-incorrect, squash and taken all at once.
- R4: When several slots mismatch, only the lowest-index one, which is the oldest, produces the redirect. At most one redirect is issued per cycle.
- R5: Slots with a higher index than the mismatching slot are not forwarded (`out_valid` bit 0).
- R6: On a mismatch, any valid slot with the branch's thread id and a strictly younger sequence number is not forwarded. Younger means that (seq − branch_seq) mod 2^SEQ_W is nonzero and has its top bit clear. The branch itself and the slots of other threads are still forwarded.
- R7: `flush_thr` is one-hot at bit `redir_tid` in a redirect cycle and zero otherwise.
- R8: `pred_err` is 1 when a forwarded slot is predicted taken but its control flag is 0.
- R9: Bit i of `out_issuable` is 1 exactly when slot i is forwarded and has its no-source flag set.
- R10: Field i of `out_tgt` (bits i*PC_W upward) holds the computed target for the mismatching slot and the predicted target for every other slot.
- R11: A slot is forwarded when it is valid and neither R5 nor R6 drops it. Every result is registered and is valid exactly one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | W | Slot occupied |
| in_seq | input | W*SEQ_W | Sequence number per slot |
| in_tid | input | W*TID_W | Thread id per slot |
| in_pred_taken | input | W | Predicted-taken bit |
| in_pred_tgt | input | W*PC_W | Predicted target |
| in_ctrl | input | W | Control instruction flag |
| in_direct | input | W | Direct (PC-relative) flag |
| in_uncond | input | W | Unconditional flag |
| in_calc_tgt | input | W*PC_W | Computed branch target |
| in_no_src | input | W | Instruction reads no sources |
| out_valid | output | W | Slot forwarded |
| out_issuable | output | W | Forwarded and issuable at once |
| out_tgt | output | W*PC_W | Forwarded target field, corrected on mismatch |
| redir_valid | output | 1 | Redirect to fetch |
| redir_tid | output | TID_W | Redirect thread |
| redir_seq | output | SEQ_W | Last good sequence number |
| redir_pc | output | PC_W | Next fetch PC |
| flush_thr | output | 2**TID_W | Per-thread queue/skid flush pulse |
| pred_err | output | 1 | Taken prediction on a non-control instruction |
| resolved_cnt | output | CNT_W | Checked branch count |
| mispred_cnt | output | CNT_W | Mispredicted branch count |

## Verification
Each result is due on the clock edge that follows the group. The bench therefore drives a new group on every falling edge and compares the previous group's outputs on the next falling edge, so the registered outputs are observed halfway between the edges. Directed groups come first and cover wrap-around of the sequence numbers and mismatches in several slots. After them, hundreds of mixed groups sweep the base sequence number through its full range. The expected forward mask, redirect fields and counter values are computed arithmetically for each group and carried from one group to the next.

// File: rtl/brc_pkg.sv
package brc_pkg;
   // Wrap-safe age test: true when diff (a - b) says a is strictly younger.
   function automatic logic seq_is_younger(input logic [31:0] diff, input int unsigned w);
      logic [31:0] msk;
      logic [31:0] d;
      msk = (32'h1 << w) - 32'h1;
      d   = diff & msk;
      return (d != 32'h0) && !d[w-1];
   endfunction
endpackage

// File: rtl/brc_slot_eval.sv
module brc_slot_eval #(
   parameter int PC_W = 16
) (
   input  logic            valid,
   input  logic            direct,
   input  logic            uncond,
   input  logic            ctrl,
   input  logic            pred_taken,
   input  logic [PC_W-1:0] pred_tgt,
   input  logic [PC_W-1:0] calc_tgt,
   output logic            checked,
   output logic            mismatch,
   output logic            bad_pred
);
   always_comb begin
      checked  = valid && direct && uncond;
      mismatch = checked && (calc_tgt != pred_tgt);
      bad_pred = valid && pred_taken && !ctrl;
   end
endmodule

// File: rtl/brc_first_pick.sv
module brc_first_pick #(
   parameter int W = 4
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] first,
   output logic [W-1:0] after
);
   logic [W:0] seen;
   always_comb begin
      seen[0] = 1'b0;
      for (int i = 0; i < W; i++) begin
         first[i]   = req[i] && !seen[i];
         after[i]   = seen[i];
         seen[i+1]  = seen[i] || req[i];
      end
   end

   // R4
   always_comb begin
      pick_onehot_chk: assert ($onehot0(first));
      pick_in_req_chk: assert ((first & ~req) == '0);
   end
endmodule

// File: rtl/branch_redirect_chk.sv
module branch_redirect_chk #(
   parameter int W     = 4,
   parameter int SEQ_W = 8,
   parameter int TID_W = 1,
   parameter int PC_W  = 16,
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         in_valid,
   input  logic [W*SEQ_W-1:0]   in_seq,
   input  logic [W*TID_W-1:0]   in_tid,
   input  logic [W-1:0]         in_pred_taken,
   input  logic [W*PC_W-1:0]    in_pred_tgt,
   input  logic [W-1:0]         in_ctrl,
   input  logic [W-1:0]         in_direct,
   input  logic [W-1:0]         in_uncond,
   input  logic [W*PC_W-1:0]    in_calc_tgt,
   input  logic [W-1:0]         in_no_src,
   output logic [W-1:0]         out_valid,
   output logic [W-1:0]         out_issuable,
   output logic [W*PC_W-1:0]    out_tgt,
   output logic                 redir_valid,
   output logic [TID_W-1:0]     redir_tid,
   output logic [SEQ_W-1:0]     redir_seq,
   output logic [PC_W-1:0]      redir_pc,
   output logic [2**TID_W-1:0]  flush_thr,
   output logic                 pred_err,
   output logic [CNT_W-1:0]     resolved_cnt,
   output logic [CNT_W-1:0]     mispred_cnt
);
   localparam int NTHR = 2**TID_W;
   localparam int IW   = $clog2(W + 1);

   generate
      if (W < 1 || W > 16) begin : g_bad_w
         $error("W must lie in 1..16");
      end
      if (SEQ_W < 2 || SEQ_W > 32) begin : g_bad_seq
         $error("SEQ_W must lie in 2..32");
      end
      if (TID_W < 1 || TID_W > 4) begin : g_bad_tid
         $error("TID_W must lie in 1..4");
      end
      if (CNT_W < IW) begin : g_bad_cnt
         $error("CNT_W too narrow for one group");
      end
   endgenerate

   logic [W-1:0] chk, mis, bad, first, after, kill, proc;

   genvar g;
   generate
      for (g = 0; g < W; g++) begin : g_slot
         brc_slot_eval #(.PC_W(PC_W)) u_eval (
            .valid      (in_valid[g]),
            .direct     (in_direct[g]),
            .uncond     (in_uncond[g]),
            .ctrl       (in_ctrl[g]),
            .pred_taken (in_pred_taken[g]),
            .pred_tgt   (in_pred_tgt[g*PC_W +: PC_W]),
            .calc_tgt   (in_calc_tgt[g*PC_W +: PC_W]),
            .checked    (chk[g]),
            .mismatch   (mis[g]),
            .bad_pred   (bad[g])
         );
      end
   endgenerate

   brc_first_pick #(.W(W)) u_pick (
      .req   (mis),
      .first (first),
      .after (after)
   );

   logic              any_mis;
   logic [SEQ_W-1:0]  m_seq;
   logic [TID_W-1:0]  m_tid;
   logic [PC_W-1:0]   m_calc;
   logic [W*PC_W-1:0] nxt_tgt;
   logic [IW-1:0]     n_resolved;
   logic [NTHR-1:0]   nxt_flush;

   always_comb begin
      any_mis = |mis;
      m_seq   = '0;
      m_tid   = '0;
      m_calc  = '0;
      for (int i = 0; i < W; i++) begin
         if (first[i]) begin
            m_seq  = m_seq  | in_seq[i*SEQ_W +: SEQ_W];
            m_tid  = m_tid  | in_tid[i*TID_W +: TID_W];
            m_calc = m_calc | in_calc_tgt[i*PC_W +: PC_W];
         end
      end
      n_resolved = '0;
      for (int i = 0; i < W; i++) begin
         kill[i] = any_mis && in_valid[i] &&
                   (in_tid[i*TID_W +: TID_W] == m_tid) &&
                   brc_pkg::seq_is_younger(32'(in_seq[i*SEQ_W +: SEQ_W]) - 32'(m_seq), SEQ_W);
         proc[i] = in_valid[i] && !after[i] && !kill[i];
         nxt_tgt[i*PC_W +: PC_W] = first[i] ? in_calc_tgt[i*PC_W +: PC_W]
                                            : in_pred_tgt[i*PC_W +: PC_W];
         n_resolved = n_resolved + IW'(proc[i] && chk[i]);
      end
      nxt_flush = '0;
      nxt_flush[m_tid] = any_mis;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= '0;
         out_issuable <= '0;
         out_tgt      <= '0;
         redir_valid  <= 1'b0;
         redir_tid    <= '0;
         redir_seq    <= '0;
         redir_pc     <= '0;
         flush_thr    <= '0;
         pred_err     <= 1'b0;
         resolved_cnt <= '0;
         mispred_cnt  <= '0;
      end else begin
         out_valid    <= proc;
         out_issuable <= proc & in_no_src;
         out_tgt      <= nxt_tgt;
         redir_valid  <= any_mis;
         redir_tid    <= m_tid;
         redir_seq    <= m_seq;
         redir_pc     <= m_calc;
         flush_thr    <= nxt_flush;
         pred_err     <= |(proc & bad);
         resolved_cnt <= resolved_cnt + CNT_W'(n_resolved);
         mispred_cnt  <= mispred_cnt + CNT_W'(any_mis);
      end
   end

   // R7
   flush_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (flush_thr == (NTHR'(1) << redir_tid)));
   // R7
   flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !redir_valid |-> (flush_thr == '0));
   // R9
   issue_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_issuable & ~out_valid) == '0);
   // R3
   mis_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mispred_cnt == $past(mispred_cnt) + CNT_W'(redir_valid));
   // R5
   branch_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (out_valid != '0));
endmodule

// File: tb/branch_redirect_chk_tb_top.sv
`timescale 1ns/1ps
module branch_redirect_chk_tb_top;
   localparam int W = 4, SEQ_W = 8, TID_W = 1, PC_W = 16, CNT_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] in_valid, in_pred_taken, in_ctrl, in_direct, in_uncond, in_no_src;
   logic [W*SEQ_W-1:0] in_seq;
   logic [W*TID_W-1:0] in_tid;
   logic [W*PC_W-1:0]  in_pred_tgt, in_calc_tgt;
   logic [W-1:0] out_valid, out_issuable;
   logic [W*PC_W-1:0] out_tgt;
   logic redir_valid, pred_err;
   logic [TID_W-1:0] redir_tid;
   logic [SEQ_W-1:0] redir_seq;
   logic [PC_W-1:0] redir_pc;
   logic [1:0] flush_thr;
   logic [CNT_W-1:0] resolved_cnt, mispred_cnt;

   branch_redirect_chk #(.W(W), .SEQ_W(SEQ_W), .TID_W(TID_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_seq(in_seq), .in_tid(in_tid),
      .in_pred_taken(in_pred_taken), .in_pred_tgt(in_pred_tgt), .in_ctrl(in_ctrl),
      .in_direct(in_direct), .in_uncond(in_uncond), .in_calc_tgt(in_calc_tgt),
      .in_no_src(in_no_src), .out_valid(out_valid), .out_issuable(out_issuable),
      .out_tgt(out_tgt), .redir_valid(redir_valid), .redir_tid(redir_tid),
      .redir_seq(redir_seq), .redir_pc(redir_pc), .flush_thr(flush_thr),
      .pred_err(pred_err), .resolved_cnt(resolved_cnt), .mispred_cnt(mispred_cnt));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // slot stimulus
   logic [SEQ_W-1:0] s_seq [W];
   logic [PC_W-1:0]  s_pt [W], s_ct [W];
   logic s_v [W], s_tid [W], s_pk [W], s_c [W], s_d [W], s_u [W], s_ns [W];

   // expectations
   logic [W-1:0] e_valid, e_iss;
   logic [W*PC_W-1:0] e_tgt;
   logic e_redir, e_err, e_tid;
   logic [SEQ_W-1:0] e_seq;
   logic [PC_W-1:0] e_pc;
   logic [1:0] e_flush;
   logic [CNT_W-1:0] e_res = '0, e_mis = '0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic drive_and_model();
      int m;
      logic [SEQ_W-1:0] d;
      m = -1;
      for (int i = 0; i < W; i++) begin
         in_valid[i] = s_v[i]; in_seq[i*SEQ_W +: SEQ_W] = s_seq[i]; in_tid[i] = s_tid[i];
         in_pred_taken[i] = s_pk[i]; in_pred_tgt[i*PC_W +: PC_W] = s_pt[i];
         in_ctrl[i] = s_c[i]; in_direct[i] = s_d[i]; in_uncond[i] = s_u[i];
         in_calc_tgt[i*PC_W +: PC_W] = s_ct[i]; in_no_src[i] = s_ns[i];
         if (m < 0 && s_v[i] && s_d[i] && s_u[i] && s_pt[i] != s_ct[i]) m = i;
      end
      e_redir = (m >= 0);
      e_tid = 0; e_seq = 0; e_pc = 0; e_flush = 0; e_err = 0;
      if (m >= 0) begin
         e_tid = s_tid[m]; e_seq = s_seq[m]; e_pc = s_ct[m];
         e_flush = 2'(1) << s_tid[m];
      end
      for (int i = 0; i < W; i++) begin
         bit keep;
         keep = s_v[i];
         if (m >= 0 && i > m) keep = 0;
         if (m >= 0 && s_tid[i] == s_tid[m]) begin
            d = s_seq[i] - s_seq[m];
            if (d != 0 && d < 8'd128) keep = 0;
         end
         e_valid[i] = keep;
         e_iss[i] = keep && s_ns[i];
         e_tgt[i*PC_W +: PC_W] = (i == m) ? s_ct[i] : s_pt[i];
         if (keep && s_pk[i] && !s_c[i]) e_err = 1;
         if (keep && s_d[i] && s_u[i]) e_res = e_res + 1'b1;
      end
      if (m >= 0) e_mis = e_mis + 1'b1;
   endtask

   task automatic compare();
      chk(out_valid == e_valid, "R5/R6/R11 out_valid", 64'(out_valid), 64'(e_valid));
      chk(out_issuable == e_iss, "R9 out_issuable", 64'(out_issuable), 64'(e_iss));
      chk(out_tgt == e_tgt, "R10 out_tgt", out_tgt, e_tgt);
      chk(redir_valid == e_redir, "R2/R3/R4 redir_valid", 64'(redir_valid), 64'(e_redir));
      if (e_redir) begin
         chk({redir_tid, redir_seq, redir_pc} == {e_tid, e_seq, e_pc}, "R3/R4 redirect fields",
             64'({redir_tid, redir_seq, redir_pc}), 64'({e_tid, e_seq, e_pc}));
      end
      chk(flush_thr == e_flush, "R7 flush_thr", 64'(flush_thr), 64'(e_flush));
      chk(pred_err == e_err, "R8 pred_err", 64'(pred_err), 64'(e_err));
      chk(resolved_cnt == e_res, "R2 resolved_cnt", 64'(resolved_cnt), 64'(e_res));
      chk(mispred_cnt == e_mis, "R3 mispred_cnt", 64'(mispred_cnt), 64'(e_mis));
   endtask

   task automatic apply();
      drive_and_model();
      @(negedge clk);
      compare();
   endtask

   task automatic clear_slots();
      for (int i = 0; i < W; i++) begin
         s_v[i] = 0; s_seq[i] = 0; s_tid[i] = 0; s_pk[i] = 0; s_pt[i] = 0;
         s_c[i] = 0; s_d[i] = 0; s_u[i] = 0; s_ct[i] = 0; s_ns[i] = 0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      clear_slots();
      drive_and_model();
      e_res = 0; e_mis = 0;
      // R1: outputs held at zero in reset despite active inputs
      for (int i = 0; i < W; i++) begin s_v[i] = 1; s_d[i] = 1; s_u[i] = 1; s_ct[i] = 16'h55; end
      drive_and_model();
      e_res = 0; e_mis = 0;
      repeat (3) @(negedge clk);
      chk({out_valid, out_issuable, redir_valid, flush_thr, pred_err} == '0, "R1 reset flags",
          64'({out_valid, out_issuable, redir_valid, flush_thr, pred_err}), 64'(0));
      chk(out_tgt == '0, "R1 reset out_tgt", out_tgt, 64'(0));
      chk(resolved_cnt == 0 && mispred_cnt == 0, "R1 reset counters",
          64'({resolved_cnt, mispred_cnt}), 64'(0));
      rst_n = 1'b1;

      // R4: mismatches in slots 2 and 3, slot 2 wins, slot 3 dropped (R5)
      clear_slots();
      for (int i = 0; i < W; i++) begin
         s_v[i] = 1; s_tid[i] = 0; s_seq[i] = 8'(10 + i); s_d[i] = 1; s_u[i] = 1; s_c[i] = 1;
         s_ct[i] = 16'(100 * i); s_pt[i] = s_ct[i];
      end
      s_pt[2] = 16'h0BAD; s_pt[3] = 16'h0BEE; s_ns[1] = 1;
      apply();
      // R6: wrap-around, branch seq 255, same-thread seq 1 earlier in group is younger
      clear_slots();
      s_v[0] = 1; s_tid[0] = 1; s_seq[0] = 8'd1;                        // younger, killed
      s_v[1] = 1; s_tid[1] = 0; s_seq[1] = 8'd2;                        // other thread kept
      s_v[2] = 1; s_tid[2] = 1; s_seq[2] = 8'd127; s_ns[2] = 1;         // diff 128: older, kept
      s_v[3] = 1; s_tid[3] = 1; s_seq[3] = 8'd255; s_d[3] = 1; s_u[3] = 1; s_c[3] = 1;
      s_ct[3] = 16'h1234; s_pt[3] = 16'h1230;
      apply();
      // R2: conditional and indirect with wrong targets are not checked; R8 bad taken
      clear_slots();
      s_v[0] = 1; s_d[0] = 1; s_c[0] = 1; s_ct[0] = 1; s_pt[0] = 2;
      s_v[1] = 1; s_u[1] = 1; s_c[1] = 1; s_ct[1] = 3; s_pt[1] = 4;
      s_v[2] = 1; s_pk[2] = 1; s_c[2] = 0;
      apply();
      // R11: idle group
      clear_slots();
      apply();

      // sweep
      for (int v = 0; v < 1500; v++) begin
         logic [SEQ_W-1:0] base;
         base = 8'(v * 53);
         for (int i = 0; i < W; i++) begin
            s_v[i]   = ($urandom % 8) != 0;
            s_tid[i] = 1'($urandom);
            s_seq[i] = base + 8'(i) + ((($urandom % 4) == 0) ? 8'($urandom % 8) - 8'd3 : 8'd0);
            s_d[i]   = 1'($urandom); s_u[i] = 1'($urandom);
            s_c[i]   = (s_d[i] && s_u[i]) ? 1'b1 : 1'($urandom);
            s_pk[i]  = 1'($urandom);
            s_ns[i]  = 1'($urandom);
            s_ct[i]  = 16'($urandom);
            s_pt[i]  = (($urandom % 3) == 0) ? (s_ct[i] ^ (16'h1 << ($urandom % 16))) : s_ct[i];
         end
         apply();
      end
      clear_slots();
      apply();
      finish_run();
   end
endmodule